// File: doc/BRIEF.md
# Planar VGA Address Mapper

This block sits between a CPU that issues accesses into the legacy VGA memory window and a 4 MB linear graphics memory that is organised as 32-bit longwords, one byte per colour plane. For every access it turns the CPU byte offset into a 20-bit longword address. For a write it also produces the set of planes to update. For a read it produces the plane whose byte is returned. The frame-buffer storage and the data path are not part of this block.

A 6-bit base value is added at longword bit 14, so the VGA window can start on any 64 KB boundary of the 4 MB memory. Three addressing schemes are supported. The first is planar addressing, with an optional page bit that can take the place of offset bit 0. The second is chain 2, selected separately for writes and for reads, in which the low address bit picks the even or odd plane pair. The third is chain 4, in which offset bits 1:0 pick one plane, and a packed variant of it compresses the address range to 64 KB. A control can also force VGA address bit 15 to zero.

The mapping is combinational. The result is captured in one output register stage: a request presented in cycle N appears on the outputs after the next rising clock edge.

Top module: `vga_plane_mapper`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request yet presented, `map_valid` is 0 and `map_laddr`, `map_plane_en` and `map_read_plane` are all zero.
- R2: `map_valid` is 1 in exactly the cycle that follows a cycle with `req_valid` high. The outputs in that cycle describe the request and the configuration sampled in the earlier cycle.
- R3: `map_laddr` equals (`cfg_base` × 2^14 + V) modulo 2^20, where V is the 16-bit VGA address defined in R4 to R7. This lets the window wrap past the top of the 4 MB memory.
- R4: When `cfg_chain4` is 0, V is the offset with bit 0 replaced by a low bit L. L is `cfg_page` when `cfg_odd_even` is 1, and offset bit 0 otherwise. With no chain mode active, a write enables exactly the planes set in `cfg_map_mask` (bit k = plane k), and a read selects plane `cfg_read_map`.
- R5: When `cfg_chain4` is 1, it overrides both chain 2 controls. A write enables plane offset[1:0] only, and only if that plane's bit is set in `cfg_map_mask`. A read selects plane offset[1:0]. V is the offset with bits 1:0 cleared.
- R6: When `cfg_chain4` and `cfg_packed4` are both 1, V is the offset shifted right by 2. `cfg_packed4` has no effect without chain 4.
- R7: When `cfg_force15` is 1, bit 15 of V is 0 in every mode. This is applied after the mapping of R4 to R6.
- R8: When `cfg_chain4` is 0 and `cfg_wchain2` is 1, a write enables `cfg_map_mask` ANDed with 4'b1010 if L is 1, and with 4'b0101 if L is 0.
- R9: When `cfg_chain4` is 0 and `cfg_rchain2` is 1, a read selects plane {`cfg_read_map`[1], L}. `cfg_rchain2` has no effect on writes and `cfg_wchain2` has no effect on reads.
- R10: For a read `map_plane_en` is 4'b0000. For a write `map_read_plane` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 16 | CPU byte offset within the VGA window |
| cfg_base | input | 6 | Window base, added at longword bit 14 |
| cfg_map_mask | input | 4 | Planes allowed for writes |
| cfg_chain4 | input | 1 | Chain 4 addressing for reads and writes |
| cfg_packed4 | input | 1 | Packed chain 4 (shift right by 2) |
| cfg_force15 | input | 1 | Force VGA address bit 15 to 0 |
| cfg_odd_even | input | 1 | Use page bit instead of offset bit 0 |
| cfg_page | input | 1 | Page bit value |
| cfg_wchain2 | input | 1 | Chain 2 for writes |
| cfg_rchain2 | input | 1 | Chain 2 for reads |
| cfg_read_map | input | 2 | Plane to read when no chain mode applies |
| map_valid | output | 1 | Registered result valid |
| map_laddr | output | 20 | Longword address in graphics memory |
| map_plane_en | output | 4 | Plane write enables |
| map_read_plane | output | 2 | Plane selected for a read |

## Verification
The assertions assume that the request and all configuration inputs are known, and stable around the clock edge, whenever `req_valid` is high, and that `req_valid` is low while reset is asserted. They relate each output only to the request and configuration of the cycle before. The bench drives every input from one task at the falling edge and holds `req_valid` low through reset. It changes configuration only together with a new request, so every sampled value is settled before the rising edge.

// File: rtl/vga_plane_mapper.sv
module vga_plane_mapper #(
  parameter int OFS_W  = 16,
  parameter int BASE_W = 6,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [3:0]        cfg_map_mask,
  input  logic              cfg_chain4,
  input  logic              cfg_packed4,
  input  logic              cfg_force15,
  input  logic              cfg_odd_even,
  input  logic              cfg_page,
  input  logic              cfg_wchain2,
  input  logic              cfg_rchain2,
  input  logic [1:0]        cfg_read_map,
  output logic              map_valid,
  output logic [ADDR_W-1:0] map_laddr,
  output logic [3:0]        map_plane_en,
  output logic [1:0]        map_read_plane
);
  localparam int BASE_LSB = ADDR_W - BASE_W;
  localparam int PAD_W    = ADDR_W - OFS_W;

  logic              low_bit;
  logic [OFS_W-1:0]  vga_raw;
  logic [OFS_W-1:0]  vga_addr;
  logic [ADDR_W-1:0] laddr_d;
  logic [3:0]        en_d;
  logic [1:0]        sel_d;
  logic              c2_wr;
  logic              c2_rd;

  assign low_bit = cfg_odd_even ? cfg_page : req_offset[0];
  assign c2_wr   = !cfg_chain4 && cfg_wchain2;
  assign c2_rd   = !cfg_chain4 && cfg_rchain2;

  always_comb begin
    if (cfg_chain4 && cfg_packed4)
      vga_raw = {2'b00, req_offset[OFS_W-1:2]};
    else if (cfg_chain4)
      vga_raw = {req_offset[OFS_W-1:2], 2'b00};
    else
      vga_raw = {req_offset[OFS_W-1:1], low_bit};
  end

  assign vga_addr = {vga_raw[OFS_W-1] & ~cfg_force15, vga_raw[OFS_W-2:0]};
  assign laddr_d  = {cfg_base, {BASE_LSB{1'b0}}} + {{PAD_W{1'b0}}, vga_addr};

  always_comb begin
    if (!req_write)
      en_d = 4'b0000;
    else if (cfg_chain4)
      en_d = cfg_map_mask & (4'b0001 << req_offset[1:0]);
    else if (c2_wr)
      en_d = cfg_map_mask & (low_bit ? 4'b1010 : 4'b0101);
    else
      en_d = cfg_map_mask;
  end

  always_comb begin
    if (req_write)
      sel_d = 2'b00;
    else if (cfg_chain4)
      sel_d = req_offset[1:0];
    else if (c2_rd)
      sel_d = {cfg_read_map[1], low_bit};
    else
      sel_d = cfg_read_map;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_valid      <= 1'b0;
      map_laddr      <= '0;
      map_plane_en   <= 4'b0000;
      map_read_plane <= 2'b00;
    end else begin
      map_valid <= req_valid;
      if (req_valid) begin
        map_laddr      <= laddr_d;
        map_plane_en   <= en_d;
        map_read_plane <= sel_d;
      end
    end
  end

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> map_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !map_valid);

  // R4
  en_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> (map_plane_en & ~$past(cfg_map_mask)) == 4'b0000);

  // R5
  chain4_single_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && cfg_chain4 |=> $countones(map_plane_en) <= 1);

  // R6
  packed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cfg_chain4 && cfg_packed4 |=>
      ((map_laddr - {$past(cfg_base), {BASE_LSB{1'b0}}}) >> (OFS_W - 2)) == '0);

  // R7
  force15_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cfg_force15 |=>
      ((map_laddr - {$past(cfg_base), {BASE_LSB{1'b0}}}) >> (OFS_W - 1)) == '0);

  // R10
  read_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> map_plane_en == 4'b0000);

  // R10
  write_plane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> map_read_plane == 2'b00);
endmodule

// File: tb/tb_vga_plane_mapper.sv
module tb_vga_plane_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_offset = '0;
  logic [5:0]  cfg_base = '0;
  logic [3:0]  cfg_map_mask = '0;
  logic        cfg_chain4 = 1'b0, cfg_packed4 = 1'b0, cfg_force15 = 1'b0;
  logic        cfg_odd_even = 1'b0, cfg_page = 1'b0;
  logic        cfg_wchain2 = 1'b0, cfg_rchain2 = 1'b0;
  logic [1:0]  cfg_read_map = '0;
  logic        map_valid;
  logic [19:0] map_laddr;
  logic [3:0]  map_plane_en;
  logic [1:0]  map_read_plane;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [19:0] laddr;
    logic [3:0]  en;
    logic [1:0]  sel;
    string       tag;
  } item_t;
  item_t sb[$];

  vga_plane_mapper dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .cfg_base(cfg_base), .cfg_map_mask(cfg_map_mask),
    .cfg_chain4(cfg_chain4), .cfg_packed4(cfg_packed4), .cfg_force15(cfg_force15),
    .cfg_odd_even(cfg_odd_even), .cfg_page(cfg_page), .cfg_wchain2(cfg_wchain2),
    .cfg_rchain2(cfg_rchain2), .cfg_read_map(cfg_read_map),
    .map_valid(map_valid), .map_laddr(map_laddr), .map_plane_en(map_plane_en),
    .map_read_plane(map_read_plane)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input bit wr, input logic [15:0] ofs, input string tag);
    item_t it;
    logic       l;
    logic [15:0] v;
    l = cfg_odd_even ? cfg_page : ofs[0];
    if (cfg_chain4) v = cfg_packed4 ? (ofs >> 2) : (ofs & 16'hFFFC);
    else            v = {ofs[15:1], l};
    if (cfg_force15) v[15] = 1'b0;
    it.laddr = 20'((32'(cfg_base) << 14) + 32'(v));
    it.en = 4'b0000;
    it.sel = 2'b00;
    if (wr) begin
      if (cfg_chain4)       it.en = cfg_map_mask[ofs[1:0]] ? (4'b0001 << ofs[1:0]) : 4'b0000;
      else if (cfg_wchain2) it.en = cfg_map_mask & (l ? 4'b1010 : 4'b0101);
      else                  it.en = cfg_map_mask;
    end else begin
      if (cfg_chain4)       it.sel = ofs[1:0];
      else if (cfg_rchain2) it.sel = {cfg_read_map[1], l};
      else                  it.sel = cfg_read_map;
    end
    it.due = cyc + 1;
    it.tag = tag;
    req_valid = 1'b1;
    req_write = wr;
    req_offset = ofs;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input logic [5:0] b, input logic [3:0] m, input bit c4, input bit p4,
                     input bit f15, input bit oe, input bit pg, input bit w2, input bit r2,
                     input logic [1:0] rm);
    cfg_base = b; cfg_map_mask = m; cfg_chain4 = c4; cfg_packed4 = p4;
    cfg_force15 = f15; cfg_odd_even = oe; cfg_page = pg;
    cfg_wchain2 = w2; cfg_rchain2 = r2; cfg_read_map = rm;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        check(map_valid == 1'b1, "R2", "valid", 32'(map_valid), 32'd1);
        check(map_laddr == it.laddr, it.tag, "laddr", 32'(map_laddr), 32'(it.laddr));
        check(map_plane_en == it.en, it.tag, "plane_en", 32'(map_plane_en), 32'(it.en));
        check(map_read_plane == it.sel, it.tag, "read_plane", 32'(map_read_plane), 32'(it.sel));
      end else if (map_valid) begin
        check(1'b0, "R2", "unexpected valid", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(map_valid == 1'b0 && map_laddr == '0 && map_plane_en == '0 && map_read_plane == '0,
          "R1", "reset outputs", {map_laddr, map_plane_en, map_read_plane, 5'b0, map_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release, no request
    check(map_valid == 1'b0 && map_laddr == '0, "R1", "idle after reset",
          {11'b0, map_laddr, map_valid}, 32'd0);

    cfg(6'd0, 4'hA, 0, 0, 0, 0, 0, 0, 0, 2'd2);
    send(1, 16'h1235, "R4");
    send(0, 16'h1235, "R4");
    send(0, 16'h1235, "R10");
    cfg(6'd0, 4'hA, 0, 0, 0, 1, 0, 0, 0, 2'd1);
    send(1, 16'h1235, "R4");
    cfg(6'd0, 4'hA, 0, 1, 0, 1, 1, 0, 0, 2'd1);
    send(0, 16'h1234, "R6");
    cfg(6'd63, 4'hF, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    send(1, 16'hFFFF, "R3");
    cfg(6'd5, 4'h3, 0, 0, 0, 0, 0, 0, 0, 2'd3);
    send(0, 16'h0100, "R3");
    @(negedge clk);

    cfg(6'd0, 4'hF, 1, 0, 0, 0, 0, 0, 0, 2'd0);
    send(1, 16'h0006, "R5");
    cfg(6'd0, 4'hB, 1, 0, 0, 0, 0, 0, 0, 2'd0);
    send(1, 16'h0006, "R5");
    send(0, 16'h0003, "R5");
    cfg(6'd0, 4'hF, 1, 0, 0, 0, 0, 1, 1, 2'd2);
    send(1, 16'h0001, "R5");
    send(0, 16'h0002, "R5");
    cfg(6'd2, 4'hF, 1, 1, 0, 0, 0, 0, 0, 2'd0);
    send(1, 16'hFFFF, "R6");
    send(0, 16'h0007, "R6");

    cfg(6'd0, 4'hF, 0, 0, 1, 0, 0, 0, 0, 2'd0);
    send(1, 16'h8001, "R7");
    cfg(6'd1, 4'hF, 1, 0, 1, 0, 0, 0, 0, 2'd0);
    send(1, 16'h8003, "R7");

    cfg(6'd0, 4'hF, 0, 0, 0, 0, 0, 1, 0, 2'd3);
    send(1, 16'h0001, "R8");
    send(1, 16'h0002, "R8");
    send(0, 16'h0001, "R9");
    cfg(6'd0, 4'h6, 0, 0, 0, 1, 1, 1, 0, 2'd0);
    send(1, 16'h0000, "R8");
    cfg(6'd0, 4'h9, 0, 0, 0, 0, 0, 0, 1, 2'd2);
    send(0, 16'h0001, "R9");
    send(1, 16'h0001, "R9");
    cfg(6'd0, 4'h9, 0, 0, 0, 1, 0, 0, 1, 2'd3);
    send(0, 16'h0001, "R9");

    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = $urandom;
      cfg(r[5:0], r[9:6], r[10], r[11], r[12], r[13], r[14], r[15], r[16], r[18:17]);
      send(r[19], 16'($urandom), "R3");
      if (r[20]) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", "pending responses", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule